// File: doc/BRIEF.md
# Serial On/Off Channel Control Register

This block is the digital front end of a sixteen-channel output driver. A serial bit stream on a data pin is clocked into a shift register by the rising edges of a serial clock. A channel latch takes its value from the shift register, and that latch drives one enable per channel. A blanking input turns every channel off at once. The most significant bit of the shift register appears on a serial output, so several blocks can be daisy-chained on one serial line.

The serial clock, data, latch and blanking pins are treated as asynchronous. Each one passes through a two-flop synchronizer into the system clock domain. The system clock must run at least four times faster than the serial clock.

The latch is level-transparent. While the latch input is high, the channel latch reloads from the shift register on every system clock, so any shift made in that window reaches the enables straight away. While the latch input is low, the channel latch keeps its contents.

Top module: `serial_chan_ctl`

## Requirements
- R1: Each rising edge of the serial clock moves the data bit into shift register bit 0 and moves every other bit one place toward bit 15.
- R2: The serial output always shows shift register bit 15. A bit therefore appears on the serial output 15 rising edges after the edge that loaded it.
- R3: While the latch input is high, the channel latch follows the shift register. A shift made during that window changes the enables within a few system clocks.
- R4: While the latch input is low, the channel latch holds its value. Toggling the serial clock or the data line does not change it.
- R5: While the blanking input is high, all sixteen enables are 0. Blanking does not alter the channel latch, so the previous enables return when blanking is released.
- R6: Channel latch bit n drives enable n. After a latched load, enable 0 shows the most recently shifted bit and enable 15 shows the bit shifted 15 edges earlier.
- R7: An active-low reset clears the shift register and the channel latch. After reset, the enables and the serial output are all 0.
- R8: Exactly one shift happens per rising edge of the serial clock. Holding the serial clock high, or its falling edge, causes no further shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sinIn | input | 1 | Serial data input (asynchronous) |
| sclkIn | input | 1 | Serial shift clock (asynchronous) |
| latIn | input | 1 | Latch-transparent level (asynchronous) |
| blankIn | input | 1 | Forces all enables off (asynchronous) |
| soutOut | output | 1 | Serial output for daisy-chaining |
| chanEn | output | 16 | Per-channel enables |

## Verification
A shift and a latch reload can fall in the same system cycle. The bench provokes this by raising the latch input and then shifting single bits while it stays high. After every such shift it compares the enables with a sixteen-deep reference of the shifted bits, which shows that the late copy still picks up the new bit. Blanking and a held latch can also coincide. The bench shifts fresh data while blanking is high and the latch input is low. It judges the result by checking that the enables are zero and that, once blanking is released, the earlier pattern returns unchanged.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic blankOn;
  } ctlStrobe_t;
endpackage

// File: rtl/chanctl_sync.sv
module chanctl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/chanctl_ctrl.sv
module chanctl_ctrl
  import chanctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkS,
  input  logic       latS,
  input  logic       blankS,
  output ctlStrobe_t str
);
  logic sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  always_comb begin
    str.shiftEn = sclkS & ~sclkPrev;
    str.loadEn  = latS;
    str.blankOn = blankS;
  end

  // A rising edge is a single-cycle event
  assert_single_shift_R8: assert property (@(posedge clk) disable iff (!rstN)
    str.shiftEn |=> !str.shiftEn);
endmodule

// File: rtl/chanctl_dp.sv
module chanctl_dp
  import chanctl_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        str,
  input  logic              sinBit,
  output logic [NUM_CH-1:0] chanEn,
  output logic              soutBit
);
  localparam int MSB = NUM_CH - 1;

  logic [NUM_CH-1:0] shiftQ;
  logic [NUM_CH-1:0] latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftQ <= '0;
    else if (str.shiftEn) shiftQ <= {shiftQ[MSB-1:0], sinBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           latchQ <= '0;
    else if (str.loadEn) latchQ <= shiftQ;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mask
    assign chanEn[ch] = latchQ[ch] & ~str.blankOn;
  end

  assign soutBit = shiftQ[MSB];

  assert_shift_R1: assert property (@(posedge clk) disable iff (!rstN)
    str.shiftEn |=> shiftQ == {$past(shiftQ[MSB-1:0]), $past(sinBit)});
  assert_noshift_R8: assert property (@(posedge clk) disable iff (!rstN)
    !str.shiftEn |=> $stable(shiftQ));
  assert_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    str.loadEn |=> latchQ == $past(shiftQ));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !str.loadEn |=> $stable(latchQ));
endmodule

// File: rtl/serial_chan_ctl.sv
module serial_chan_ctl
  import chanctl_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sinIn,
  input  logic              sclkIn,
  input  logic              latIn,
  input  logic              blankIn,
  output logic              soutOut,
  output logic [NUM_CH-1:0] chanEn
);
  localparam int NUM_IN = 4;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  ctlStrobe_t        str;

  assign rawIn = {blankIn, latIn, sclkIn, sinIn};

  chanctl_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  chanctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkS(syncIn[1]), .latS(syncIn[2]), .blankS(syncIn[3]),
    .str(str)
  );

  chanctl_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .sinBit(syncIn[0]),
    .chanEn(chanEn), .soutBit(soutOut)
  );

  assert_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    str.blankOn |-> chanEn == '0);
endmodule

// File: tb/serial_chan_ctl_bench.sv
module serial_chan_ctl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sinIn = 1'b0, sclkIn = 1'b0, latIn = 1'b0, blankIn = 1'b0;
  logic soutOut;
  logic [15:0] chanEn;

  int checks = 0;
  int errors = 0;
  logic [15:0] refShift = '0;
  logic [15:0] refLatch = '0;

  localparam logic [15:0] PATS [6] = '{16'hA5C3, 16'h0001, 16'h8000,
                                       16'hFFFF, 16'h1234, 16'h7E81};

  always #2.5 clk = ~clk;

  serial_chan_ctl u_serial_chan_ctl (
    .clk(clk), .rstN(rstN), .sinIn(sinIn), .sclkIn(sclkIn), .latIn(latIn),
    .blankIn(blankIn), .soutOut(soutOut), .chanEn(chanEn)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b, input int highCycles);
    sinIn = b;
    waitClk(4);
    sclkIn = 1'b1;
    waitClk(highCycles);
    sclkIn = 1'b0;
    waitClk(6);
    refShift = {refShift[14:0], b};
    if (latIn) refLatch = refShift;
  endtask

  task automatic pulseLat();
    latIn = 1'b1;
    waitClk(8);
    latIn = 1'b0;
    waitClk(6);
    refLatch = refShift;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    waitClk(5);
    check("R7 reset enables", chanEn, 16'h0000);
    check("R7 reset sout", {15'd0, soutOut}, 16'h0000);
    rstN = 1'b1;
    waitClk(5);
    check("R7 enables after reset release", chanEn, 16'h0000);

    // Vector table: shift with latch low, then latch
    foreach (PATS[p]) begin
      for (int i = 15; i >= 0; i--) begin
        shiftBit(PATS[p][i], 6);
        check("R2 sout is bit 15", {15'd0, soutOut}, {15'd0, refShift[15]});
      end
      check("R4 latch holds while shifting", chanEn, refLatch);
      check("R1 sout after full load", {15'd0, soutOut}, {15'd0, PATS[p][15]});
      pulseLat();
      check("R6 channel mapping", chanEn, PATS[p]);
    end

    // Latch transparent: shifts go straight through
    latIn = 1'b1;
    waitClk(6);
    refLatch = refShift;
    for (int i = 0; i < 20; i++) begin
      shiftBit(((i * 7) % 3) == 0, 5);
      check("R3 transparent latch follows", chanEn, refShift);
    end
    check("R6 channel 0 shows newest bit", {15'd0, chanEn[0]}, {15'd0, refShift[0]});
    latIn = 1'b0;
    waitClk(6);

    // Blank, with shifting under blank and latch low
    blankIn = 1'b1;
    waitClk(6);
    check("R5 blank forces off", chanEn, 16'h0000);
    for (int i = 0; i < 5; i++) shiftBit(1'b1, 5);
    check("R5 still off under blank", chanEn, 16'h0000);
    blankIn = 1'b0;
    waitClk(6);
    check("R5 latch preserved across blank", chanEn, refLatch);

    // One shift per rising edge even with sclk held high long
    shiftBit(1'b0, 40);
    shiftBit(1'b1, 40);
    pulseLat();
    check("R8 single shift per edge", chanEn, refShift);
    check("R8 sout after long high", {15'd0, soutOut}, {15'd0, refShift[15]});

    // Reset mid-operation
    rstN = 1'b0;
    waitClk(3);
    check("R7 reset clears enables", chanEn, 16'h0000);
    rstN = 1'b1;
    refShift = '0;
    refLatch = '0;
    waitClk(4);
    pulseLat();
    check("R7 shift register cleared", chanEn, 16'h0000);

    finishRun();
  end
endmodule